// File: doc/BRIEF.md
# SPI Message Transfer Sequencer

This block sits between a queue of transfer descriptors and a byte-wide SPI shift engine. A message is one or more descriptors, and the final descriptor is marked with a last flag. Each descriptor carries:

- a byte count (at least one),
- flags that say whether transmit bytes come from a stream and whether received bytes go to a sink,
- a hold time in microseconds that follows the transfer,
- a flag that asks for chip select to drop before the next transfer of the same message.

The sequencer loads the message configuration word into the engine and asserts chip select. It then feeds bytes one at a time and streams the received bytes out. When the engine reports a write collision, the sequencer resends the byte. When the engine reports a mode fault, it abandons the message. At the end of each message it pulses a completion strobe, together with an error flag and the number of bytes moved by transfers that completed.

The microsecond hold time is counted with a prescaler of `CLK_PER_US` clock cycles. Engine status events that arrive while no byte is in flight are flagged as spurious and otherwise ignored.

Top module: `spi_msg_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `desc_ready` is 1, and `eng_wr`, `rx_valid`, `msg_done` and `spurious` are 0.
- R2: When a descriptor is accepted while idle, on the next cycle `cs_n` is 0, `eng_cfg` holds the `msg_cfg` value that was present at acceptance, and `eng_wr` pulses with the first byte.
- R3: A descriptor with `desc_has_tx`=0 sends every byte as 0x00 and never raises `tx_take`. With `desc_has_tx`=1, each new byte is `tx_data` and `tx_take` is high in the cycle it is consumed.
- R4: Each byte completion without collision or fault pulses `rx_valid` with `eng_rdata` on the next cycle, but only when `desc_has_rx`=1.
- R5: A transfer issues exactly `desc_len` counted byte writes before its hold phase begins.
- R6: On `eng_done` with `eng_wcol`=1, the previous byte is written again on the next cycle. No byte is counted, no `tx_take` occurs and no `rx_valid` is produced. `eng_wcol` takes priority over `eng_modf`.
- R7: On `eng_done` with `eng_modf`=1 (and `eng_wcol`=0) during a transfer, the next cycle shows `cs_n`=1, `msg_done`=1, `msg_err`=1, and `msg_bytes` equal to the sum of lengths of the message's earlier, finished transfers. The block then returns to idle.
- R8: After the final byte of a transfer, the hold phase lasts D·`CLK_PER_US`+1 cycles, where D is the descriptor's delay. The completion, or readiness for the next descriptor, shows on the cycle after that.
- R9: After the hold of a descriptor with `desc_last`=1, `msg_done` pulses with `msg_err`=0, `cs_n`=1, and `msg_bytes` equal to the sum of all the message's transfer lengths.
- R10: Between transfers of one message, `cs_n` goes to 1 only when the finished descriptor had `desc_cs_change`=1, and it returns to 0 when the next descriptor is accepted. Otherwise `cs_n` stays 0.
- R11: `eng_done` seen while idle, holding or waiting for a descriptor pulses `spurious` on the next cycle and causes no write and no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_cfg | input | CFG_W | Mode and rate word, latched at message start |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer can accept a descriptor |
| desc_len | input | LEN_W | Bytes in the transfer (nonzero) |
| desc_has_tx | input | 1 | Transmit bytes come from `tx_data` |
| desc_has_rx | input | 1 | Received bytes go to the rx stream |
| desc_delay_us | input | DLY_W | Hold after the transfer, in microseconds |
| desc_cs_change | input | 1 | Drop chip select before the next transfer |
| desc_last | input | 1 | Final transfer of the message |
| tx_data | input | 8 | Current transmit stream byte |
| tx_take | output | 1 | Transmit byte consumed this cycle |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| eng_cfg | output | CFG_W | Configuration applied to the engine |
| eng_wr | output | 1 | Byte write strobe to the engine |
| eng_wdata | output | 8 | Byte to shift out |
| eng_done | input | 1 | Engine status event |
| eng_rdata | input | 8 | Byte shifted in |
| eng_wcol | input | 1 | Write collision flag with `eng_done` |
| eng_modf | input | 1 | Mode fault flag with `eng_done` |
| cs_n | output | 1 | Active-low chip select |
| msg_done | output | 1 | Message completion pulse |
| msg_err | output | 1 | Completion ended by mode fault |
| msg_bytes | output | BYTES_W | Bytes of completed transfers |
| spurious | output | 1 | Status event seen with no byte in flight |

## Verification
The bench builds the block with `CLK_PER_US`=3, `LEN_W`=6, `DLY_W`=4 and `BYTES_W`=10. Using three cycles per microsecond exercises the prescaler wrap. It also keeps hold phases short enough that the exact cycle count D·3+1 can be measured for delays of 0, 1, 2 and 3. The small widths keep messages short, so multi-transfer messages, the chip-select release between transfers and a fault in a later transfer all fit in a few hundred cycles.

// File: rtl/spi_msg_seq.sv
module spi_msg_seq #(
  parameter int LEN_W      = 8,
  parameter int DLY_W      = 8,
  parameter int CLK_PER_US = 100,
  parameter int BYTES_W    = 16,
  parameter int CFG_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   msg_cfg,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [LEN_W-1:0]   desc_len,
  input  logic               desc_has_tx,
  input  logic               desc_has_rx,
  input  logic [DLY_W-1:0]   desc_delay_us,
  input  logic               desc_cs_change,
  input  logic               desc_last,
  input  logic [7:0]         tx_data,
  output logic               tx_take,
  output logic               rx_valid,
  output logic [7:0]         rx_data,
  output logic [CFG_W-1:0]   eng_cfg,
  output logic               eng_wr,
  output logic [7:0]         eng_wdata,
  input  logic               eng_done,
  input  logic [7:0]         eng_rdata,
  input  logic               eng_wcol,
  input  logic               eng_modf,
  output logic               cs_n,
  output logic               msg_done,
  output logic               msg_err,
  output logic [BYTES_W-1:0] msg_bytes,
  output logic               spurious
);
  localparam int TICK_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(CLK_PER_US - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT, S_NEXT} state_t;
  state_t state;

  logic [LEN_W-1:0]   rem, cur_len;
  logic [DLY_W-1:0]   dly, us_left;
  logic [TICK_W-1:0]  tick;
  logic               has_tx, has_rx, chg, last;
  logic [7:0]         last_tx;
  logic [BYTES_W-1:0] actual;

  logic accept, byte_ok, send_next, use_tx;
  logic [7:0] fresh;

  assign desc_ready = (state == S_IDLE) || (state == S_NEXT);
  assign accept     = desc_ready && desc_valid;
  assign byte_ok    = (state == S_XFER) && eng_done && !eng_wcol && !eng_modf;
  assign send_next  = byte_ok && (rem != LEN_W'(1));
  assign use_tx     = accept ? desc_has_tx : has_tx;
  assign fresh      = use_tx ? tx_data : 8'h00;
  assign tx_take    = (accept && desc_has_tx) || (send_next && has_tx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rem       <= '0;
      cur_len   <= '0;
      dly       <= '0;
      us_left   <= '0;
      tick      <= '0;
      has_tx    <= 1'b0;
      has_rx    <= 1'b0;
      chg       <= 1'b0;
      last      <= 1'b0;
      last_tx   <= '0;
      actual    <= '0;
      eng_cfg   <= '0;
      eng_wr    <= 1'b0;
      eng_wdata <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      cs_n      <= 1'b1;
      msg_done  <= 1'b0;
      msg_err   <= 1'b0;
      msg_bytes <= '0;
      spurious  <= 1'b0;
    end else begin
      eng_wr   <= 1'b0;
      rx_valid <= 1'b0;
      msg_done <= 1'b0;
      spurious <= eng_done && (state != S_XFER);
      case (state)
        S_IDLE, S_NEXT: begin
          if (accept) begin
            if (state == S_IDLE) begin
              actual  <= '0;
              eng_cfg <= msg_cfg;
            end
            cur_len   <= desc_len;
            rem       <= desc_len;
            has_tx    <= desc_has_tx;
            has_rx    <= desc_has_rx;
            dly       <= desc_delay_us;
            chg       <= desc_cs_change;
            last      <= desc_last;
            cs_n      <= 1'b0;
            eng_wr    <= 1'b1;
            eng_wdata <= fresh;
            last_tx   <= fresh;
            state     <= S_XFER;
          end
        end
        S_XFER: begin
          if (eng_done) begin
            if (eng_wcol) begin
              eng_wr    <= 1'b1;
              eng_wdata <= last_tx;
            end else if (eng_modf) begin
              cs_n      <= 1'b1;
              msg_done  <= 1'b1;
              msg_err   <= 1'b1;
              msg_bytes <= actual;
              state     <= S_IDLE;
            end else begin
              rx_valid <= has_rx;
              rx_data  <= eng_rdata;
              rem      <= rem - LEN_W'(1);
              if (rem == LEN_W'(1)) begin
                us_left <= dly;
                tick    <= '0;
                state   <= S_WAIT;
              end else begin
                eng_wr    <= 1'b1;
                eng_wdata <= fresh;
                last_tx   <= fresh;
              end
            end
          end
        end
        S_WAIT: begin
          if (us_left == '0) begin
            actual <= actual + BYTES_W'(cur_len);
            if (last) begin
              cs_n      <= 1'b1;
              msg_done  <= 1'b1;
              msg_err   <= 1'b0;
              msg_bytes <= actual + BYTES_W'(cur_len);
              state     <= S_IDLE;
            end else begin
              if (chg) cs_n <= 1'b1;
              state <= S_NEXT;
            end
          end else if (tick == TICK_MAX) begin
            tick    <= '0;
            us_left <= us_left - DLY_W'(1);
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> cs_n); // R1
  AST_WRITE_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |-> (state == S_XFER) && !cs_n); // R2
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr && !has_tx |-> eng_wdata == 8'h00); // R3
  AST_RX_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> has_rx); // R4
  AST_WCOL_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == S_XFER && eng_done && eng_wcol) |->
      eng_wr && (eng_wdata == $past(last_tx)) && !rx_valid); // R6
  AST_MODF_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == S_XFER && eng_done && !eng_wcol && eng_modf) |->
      msg_done && msg_err && cs_n && (state == S_IDLE)); // R7
  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> cs_n && (state == S_IDLE)); // R9
  AST_SPURIOUS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && (state != S_XFER) && !desc_valid |=> spurious && !eng_wr && !rx_valid); // R11
endmodule

// File: tb/spi_msg_seq_tb.sv
module spi_msg_seq_tb_top;
  localparam int CPU = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] msg_cfg = '0;
  logic desc_valid = 0, desc_has_tx = 0, desc_has_rx = 0, desc_cs_change = 0, desc_last = 0;
  logic [5:0] desc_len = '0;
  logic [3:0] desc_delay_us = '0;
  logic [7:0] tx_data, eng_rdata = '0;
  logic eng_done = 0, eng_wcol = 0, eng_modf = 0;
  logic desc_ready, tx_take, rx_valid, eng_wr, cs_n, msg_done, msg_err, spurious;
  logic [7:0] rx_data, eng_cfg, eng_wdata;
  logic [9:0] msg_bytes;
  logic [7:0] tx_idx = '0;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;
  assign tx_data = 8'hA0 + tx_idx;
  always @(posedge clk) if (tx_take) tx_idx <= tx_idx + 8'd1;

  spi_msg_seq #(.LEN_W(6), .DLY_W(4), .CLK_PER_US(CPU), .BYTES_W(10), .CFG_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_cfg(msg_cfg), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_len(desc_len), .desc_has_tx(desc_has_tx), .desc_has_rx(desc_has_rx),
    .desc_delay_us(desc_delay_us), .desc_cs_change(desc_cs_change), .desc_last(desc_last),
    .tx_data(tx_data), .tx_take(tx_take), .rx_valid(rx_valid), .rx_data(rx_data),
    .eng_cfg(eng_cfg), .eng_wr(eng_wr), .eng_wdata(eng_wdata), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .eng_wcol(eng_wcol), .eng_modf(eng_modf), .cs_n(cs_n),
    .msg_done(msg_done), .msg_err(msg_err), .msg_bytes(msg_bytes), .spurious(spurious));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input int len, input bit tx, input bit rx, input int dly, input bit chg, input bit lst);
    desc_len = 6'(len); desc_has_tx = tx; desc_has_rx = rx;
    desc_delay_us = 4'(dly); desc_cs_change = chg; desc_last = lst; desc_valid = 1;
    for (int i = 0; i < 200 && !desc_ready; i++) @(negedge clk);
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic serve(input logic [7:0] exp_w, input logic [7:0] rd, input bit wc, input bit mf, input bit exp_rx, input string req);
    for (int i = 0; i < 200 && !eng_wr; i++) @(negedge clk);
    chk(eng_wr && eng_wdata == exp_w, req, eng_wdata, exp_w);
    @(negedge clk);
    eng_done = 1; eng_rdata = rd; eng_wcol = wc; eng_modf = mf;
    @(negedge clk);
    eng_done = 0; eng_wcol = 0; eng_modf = 0;
    if (!wc && !mf) begin
      chk(rx_valid == exp_rx, {req, " rx_valid"}, rx_valid, exp_rx);
      if (exp_rx) chk(rx_data == rd, {req, " rx_data"}, rx_data, rd);
    end
  endtask

  task automatic wait_done(input int exp_n);
    int n = 0;
    while (!msg_done && n < 300) begin @(negedge clk); n++; end
    if (exp_n >= 0) chk(n == exp_n, "R8 hold cycles", n, exp_n);
  endtask

  task automatic t_reset();
    chk(cs_n && desc_ready && !eng_wr && !rx_valid && !msg_done && !spurious, "R1 reset state",
        {cs_n, desc_ready, eng_wr, rx_valid, msg_done, spurious}, 6'b110000);
  endtask

  task automatic t_single();
    msg_cfg = 8'h5A;
    push(3, 1, 1, 0, 0, 1);
    chk(!cs_n, "R2 cs asserted", cs_n, 0);
    chk(eng_cfg == 8'h5A, "R2 cfg latched", eng_cfg, 8'h5A);
    for (int k = 0; k < 3; k++) serve(8'hA0 + tx_idx - 8'd1, 8'h30 + 8'(k), 0, 0, 1, "R3 R4 R5 byte");
    chk(!eng_wr, "R5 no extra write", eng_wr, 0);
    wait_done(1);
    chk(!msg_err && msg_bytes == 10'd3 && cs_n, "R9 single done", {msg_err, cs_n, msg_bytes}, {2'b01, 10'd3});
  endtask

  task automatic t_notx_norx();
    logic [7:0] idx0 = tx_idx;
    push(2, 0, 0, 2, 0, 1);
    serve(8'h00, 8'h11, 0, 0, 0, "R3 R4 zero fill");
    serve(8'h00, 8'h12, 0, 0, 0, "R3 R4 zero fill");
    chk(tx_idx == idx0, "R3 no tx_take", tx_idx, idx0);
    wait_done(2 * CPU + 1);
    chk(msg_bytes == 10'd2 && !msg_err, "R9 bytes", msg_bytes, 2);
  endtask

  task automatic t_wcol();
    logic [7:0] b0;
    push(2, 1, 1, 1, 0, 1);
    b0 = tx_data - 8'd1;
    serve(b0, 8'h00, 1, 1, 0, "R6 first send");
    chk(eng_wr && eng_wdata == b0, "R6 resend same byte", eng_wdata, b0);
    chk(!rx_valid && tx_data == b0 + 8'd1, "R6 no count", tx_data, b0 + 8'd1);
    serve(b0, 8'h21, 0, 0, 1, "R6 retry byte");
    serve(b0 + 8'd1, 8'h22, 0, 0, 1, "R6 second byte");
    wait_done(CPU + 1);
    chk(msg_bytes == 10'd2, "R6 bytes uncounted", msg_bytes, 2);
  endtask

  task automatic t_two(input bit chg);
    push(1, 0, 1, 1, chg, 0);
    serve(8'h00, 8'h41, 0, 0, 1, "R10 xfer1");
    for (int i = 0; i < 50 && !desc_ready; i++) @(negedge clk);
    chk(cs_n == chg, "R10 cs between transfers", cs_n, chg);
    push(2, 0, 1, 0, 0, 1);
    chk(!cs_n, "R10 cs reasserted", cs_n, 0);
    serve(8'h00, 8'h42, 0, 0, 1, "R10 xfer2");
    serve(8'h00, 8'h43, 0, 0, 1, "R10 xfer2");
    wait_done(1);
    chk(msg_bytes == 10'd3 && !msg_err, "R9 sum of lengths", msg_bytes, 3);
  endtask

  task automatic t_modf();
    push(1, 0, 0, 0, 0, 0);
    serve(8'h00, 8'h00, 0, 0, 0, "R7 xfer1");
    push(2, 0, 0, 0, 0, 1);
    serve(8'h00, 8'h00, 0, 1, 0, "R7 faulted byte");
    chk(msg_done && msg_err && cs_n, "R7 abort", {msg_done, msg_err, cs_n}, 3'b111);
    chk(msg_bytes == 10'd1, "R7 bytes", msg_bytes, 1);
    @(negedge clk);
    chk(desc_ready && !eng_wr, "R7 back to idle", desc_ready, 1);
  endtask

  task automatic t_spur();
    eng_done = 1; @(negedge clk); eng_done = 0;
    chk(spurious && !eng_wr && !rx_valid && cs_n, "R11 idle event", {spurious, eng_wr, rx_valid}, 3'b100);
    push(1, 0, 1, 3, 0, 1);
    serve(8'h00, 8'h55, 0, 0, 1, "R11 byte");
    eng_done = 1; eng_rdata = 8'h99; @(negedge clk); eng_done = 0;
    chk(spurious && !rx_valid && !eng_wr, "R11 wait event", {spurious, rx_valid, eng_wr}, 3'b100);
    wait_done(-1);
    chk(!msg_err && msg_bytes == 10'd1, "R11 msg unaffected", msg_bytes, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_notx_norx();
    t_wcol();
    t_two(0);
    t_two(1);
    t_modf();
    t_spur();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule